// File: doc/BRIEF.md
# Four-Phase Shared-Bus Read Link

This block carries a single-word read between two independently clocked sides over one set of shared wires. Addresses and data use the same wires. The requester side takes a read command from a local port. It places the address on the shared wires and then waits for the data to come back. The responder side holds a read-only word array and answers from it. Three control lines pass between the two sides, and no clock edge is common to both:

- Request, raised by the requester.
- Acknowledge, raised by each side in turn.
- Data-valid, raised by the responder.

Ownership of the shared wires moves one step at a time:

1. The requester drives the address and raises Request.
2. The responder raises its acknowledge.
3. The requester lets go of the wires and drops Request.
4. The responder drives the word and raises data-valid.
5. The requester captures the word and raises its own acknowledge.
6. The responder stops driving and drops data-valid.
7. Everything falls back to zero before a new read can start.

Every control line passes through a two-flop synchronizer in the receiving clock domain. Each side drives the shared wires through its own enable, and the wires are resolved from those enables. A cycle limit on each phase stops the requester from hanging when the responder stops answering.

Top module: `shbus_read_link`

## Requirements
- R1: After reset:
  - `cmd_ready` is 1.
  - `busy`, `done`, `err`, `req_drive` and `rsp_drive` are 0.
- R2: When a command is accepted (`cmd_valid` and `cmd_ready` high at a rising `clk_a` edge), the requester from the next cycle onwards:
  - asserts `req_drive`;
  - puts the address, zero-extended to the bus width, on `bus_lines`.
- R3: The responder drives the shared wires only after the requester has released them for that read.
- R4: A completed read pulses `done` and returns on `rdata` the word at the requested index. Array word i is ((i+1)*40503 mod 2^32) XOR 0xC3A5, truncated to DW bits.
- R5: `req_drive` and `rsp_drive` are never high together.
- R6: `done` lasts one `clk_a` cycle. `rdata` keeps its value after that.
- R7: If a phase gets no answer for TIMEOUT `clk_a` cycles, the requester:
  - pulses `err` and does not pulse `done`;
  - releases its lines;
  - returns to idle, exactly TIMEOUT+1 falling edges after the accepting edge.

  A later read then completes normally.
- R8: While a read is in progress:
  - `cmd_ready` is low;
  - a `cmd_valid` pulse has no effect on the read in flight.

  A new command is accepted only when the requester is idle and both incoming control lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Requester clock |
| rst_a_n | input | 1 | Requester reset, active low, asynchronous assert |
| clk_b | input | 1 | Responder clock |
| rst_b_n | input | 1 | Responder reset, active low, asynchronous assert |
| cmd_valid | input | 1 | Read command present |
| cmd_addr | input | AW | Word index to read |
| cmd_ready | output | 1 | Requester idle and control lines quiet |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle read completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| rdata | output | DW | Last word read |
| bus_lines | output | DW | Resolved shared address/data wires |
| req_drive | output | 1 | Requester enable on the shared wires |
| rsp_drive | output | 1 | Responder enable on the shared wires |

## Verification
Reads are run at the lowest index, the highest index and two middle indices. This shows that the responder decodes the address from the wires rather than replaying a fixed word. Reads are also issued back to back, which shows that the quiet-lines check lets consecutive transfers follow each other without leftover phases. A command pulse given during a read shows that a second request cannot slip into the transfer in flight. Holding the responder in reset separates the timeout path from a slow but working handshake. A read after the timeout shows that recovery works. The two clocks are unrelated in period, so the order of ownership on the wires is checked across both clock domains.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_ADDR,
    RQ_WAIT,
    RQ_FIN,
    RQ_DRAIN
  } rq_state_e;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_ACKED,
    RS_SEND,
    RS_END
  } rs_state_e;
endpackage

// File: rtl/shbus_sync2.sv
module shbus_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/shbus_rst_sync.sv
module shbus_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/shbus_requester.sv
module shbus_requester
  import shbus_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 4,
  parameter int TIMEOUT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  input  logic          peer_ack_i,
  input  logic          peer_rdy_i,
  input  logic [DW-1:0] bus_i,
  output logic          req_o,
  output logic          ack_o,
  output logic          oe_o,
  output logic [DW-1:0] bus_o
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic ack_s, rdy_s, quiet;
  rq_state_e state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata_q;
  logic req_q, req_d, ack_q, ack_d, oe_q, oe_d;
  logic done_q, done_d, err_q, err_d;
  logic addr_en, data_en;

  shbus_sync2 #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({peer_ack_i, peer_rdy_i}),
    .q    ({ack_s, rdy_s})
  );

  assign quiet = !ack_s && !rdy_s;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q + 1'b1;
    req_d   = req_q;
    ack_d   = ack_q;
    oe_d    = oe_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    addr_en = 1'b0;
    data_en = 1'b0;
    unique case (state_q)
      RQ_IDLE: begin
        tmr_d = '0;
        if (cmd_valid && quiet) begin
          state_d = RQ_ADDR;
          req_d   = 1'b1;
          oe_d    = 1'b1;
          addr_en = 1'b1;
        end
      end
      RQ_ADDR: if (ack_s) begin
        state_d = RQ_WAIT;
        req_d   = 1'b0;
        oe_d    = 1'b0;
        tmr_d   = '0;
      end
      RQ_WAIT: if (rdy_s) begin
        state_d = RQ_FIN;
        ack_d   = 1'b1;
        data_en = 1'b1;
        tmr_d   = '0;
      end
      RQ_FIN: if (!rdy_s) begin
        state_d = RQ_DRAIN;
        ack_d   = 1'b0;
        tmr_d   = '0;
      end
      RQ_DRAIN: if (quiet) begin
        state_d = RQ_IDLE;
        done_d  = 1'b1;
        tmr_d   = '0;
      end
      default: state_d = RQ_IDLE;
    endcase
    if (state_q != RQ_IDLE && state_d == state_q && tmr_q == TW'(TIMEOUT - 1)) begin
      state_d = RQ_IDLE;
      req_d   = 1'b0;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
      err_d   = 1'b1;
      tmr_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RQ_IDLE;
      tmr_q   <= '0;
      req_q   <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      req_q   <= req_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= cmd_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (data_en) rdata_q <= bus_i;
  end

  assign cmd_ready = (state_q == RQ_IDLE) && quiet;
  assign busy      = (state_q != RQ_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rdata     = rdata_q;
  assign req_o     = req_q;
  assign ack_o     = ack_q;
  assign oe_o      = oe_q;
  assign bus_o     = DW'(addr_q);

  assert_addr_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> (oe_q && bus_o[AW-1:0] == $past(cmd_addr)));
  assert_release_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(oe_q) && !err_q) |-> $past(ack_s));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q < TW'(TIMEOUT));
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (state_q == RQ_IDLE && !req_q && !ack_q && !oe_q));
  assert_quiet_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(!ack_s && !rdy_s));
endmodule

// File: rtl/shbus_responder.sv
module shbus_responder
  import shbus_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          peer_req_i,
  input  logic          peer_ack_i,
  input  logic [DW-1:0] bus_i,
  output logic          ack_o,
  output logic          rdy_o,
  output logic          oe_o,
  output logic [DW-1:0] bus_o
);
  function automatic logic [DW-1:0] word_at(input int idx);
    logic [31:0] t;
    t = (32'(idx) + 32'd1) * 32'd40503;
    return t[DW-1:0] ^ DW'(16'hC3A5);
  endfunction

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = word_at(i);
  end

  logic req_s, ack_s;
  rs_state_e state_q, state_d;
  logic [AW-1:0] idx_q;
  logic [DW-1:0] data_q;
  logic ack_q, ack_d, rdy_q, rdy_d, oe_q, oe_d;
  logic idx_en, data_en;

  shbus_sync2 #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({peer_req_i, peer_ack_i}),
    .q    ({req_s, ack_s})
  );

  always_comb begin
    state_d = state_q;
    ack_d   = ack_q;
    rdy_d   = rdy_q;
    oe_d    = oe_q;
    idx_en  = 1'b0;
    data_en = 1'b0;
    unique case (state_q)
      RS_IDLE: if (req_s) begin
        state_d = RS_ACKED;
        ack_d   = 1'b1;
        idx_en  = 1'b1;
      end
      RS_ACKED: if (!req_s) begin
        state_d = RS_SEND;
        ack_d   = 1'b0;
        rdy_d   = 1'b1;
        oe_d    = 1'b1;
        data_en = 1'b1;
      end
      RS_SEND: if (ack_s) begin
        state_d = RS_END;
        rdy_d   = 1'b0;
        oe_d    = 1'b0;
      end
      RS_END: if (!ack_s) state_d = RS_IDLE;
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      ack_q   <= 1'b0;
      rdy_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      rdy_q   <= rdy_d;
      oe_q    <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= bus_i[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= mem[idx_q];
  end

  assign ack_o = ack_q;
  assign rdy_o = rdy_q;
  assign oe_o  = oe_q;
  assign bus_o = data_q;

  assert_drive_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(!req_s));
  assert_ready_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> oe_q);
  assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> $past(ack_s));
endmodule

// File: rtl/shbus_read_link.sv
module shbus_read_link #(
  parameter int DW      = 16,
  parameter int DEPTH   = 16,
  parameter int TIMEOUT = 64,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk_a,
  input  logic          rst_a_n,
  input  logic          clk_b,
  input  logic          rst_b_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] bus_lines,
  output logic          req_drive,
  output logic          rsp_drive
);
  logic rst_a_sn, rst_b_sn;
  logic line_req, line_ack_a, line_ack_b, line_rdy;
  logic [DW-1:0] bus_from_a, bus_from_b;

  shbus_rst_sync u_rst_a (.clk(clk_a), .rst_n_i(rst_a_n), .rst_n_o(rst_a_sn));
  shbus_rst_sync u_rst_b (.clk(clk_b), .rst_n_i(rst_b_n), .rst_n_o(rst_b_sn));

  shbus_requester #(.DW(DW), .AW(AW), .TIMEOUT(TIMEOUT)) u_req (
    .clk       (clk_a),
    .rst_n     (rst_a_sn),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rdata     (rdata),
    .peer_ack_i(line_ack_b),
    .peer_rdy_i(line_rdy),
    .bus_i     (bus_lines),
    .req_o     (line_req),
    .ack_o     (line_ack_a),
    .oe_o      (req_drive),
    .bus_o     (bus_from_a)
  );

  shbus_responder #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rsp (
    .clk       (clk_b),
    .rst_n     (rst_b_sn),
    .peer_req_i(line_req),
    .peer_ack_i(line_ack_a),
    .bus_i     (bus_lines),
    .ack_o     (line_ack_b),
    .rdy_o     (line_rdy),
    .oe_o      (rsp_drive),
    .bus_o     (bus_from_b)
  );

  assign bus_lines = req_drive ? bus_from_a : (rsp_drive ? bus_from_b : '0);

  assert_single_driver_R5: assert property (@(posedge clk_a) disable iff (!rst_a_sn)
    !(req_drive && rsp_drive));
  assert_single_driver_b_R5: assert property (@(posedge clk_b) disable iff (!rst_b_sn)
    !(req_drive && rsp_drive));
endmodule

// File: tb/shbus_read_link_test.sv
`timescale 1ns/1ps
module shbus_read_link_test;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int TO = 40;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a_n, rst_b_n;
  logic cmd_valid;
  logic [AW-1:0] cmd_addr;
  logic cmd_ready, busy, done, err, req_drive, rsp_drive;
  logic [DW-1:0] rdata, bus_lines;

  int checks = 0;
  int failures = 0;
  int overlap_a = 0;
  int overlap_b = 0;
  bit finished = 1'b0;

  always #4 clk_a = ~clk_a;
  always #5.5 clk_b = ~clk_b;

  shbus_read_link #(.DW(DW), .DEPTH(DEPTH), .TIMEOUT(TO)) uut (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_lines(bus_lines), .req_drive(req_drive), .rsp_drive(rsp_drive)
  );

  always @(negedge clk_a) if (rst_a_n && req_drive && rsp_drive) overlap_a++;
  always @(negedge clk_b) if (rst_b_n && req_drive && rsp_drive) overlap_b++;

  function automatic logic [DW-1:0] expect_word(input int idx);
    logic [31:0] t;
    t = (32'(idx) + 32'd1) * 32'd40503;
    return t[DW-1:0] ^ 16'hC3A5;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a);
    for (int i = 0; i < 200 && !cmd_ready; i++) @(negedge clk_a);
    cmd_valid = 1'b1;
    cmd_addr  = a;
    @(negedge clk_a);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_a_n = 1'b0; rst_b_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0;
    repeat (4) @(negedge clk_a);
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    repeat (6) @(negedge clk_a);
    check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    check({busy, done, err} == 3'b000, "R1 busy/done/err", {busy, done, err}, 0);
    check({req_drive, rsp_drive} == 2'b00, "R1 drives", {req_drive, rsp_drive}, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a);
    bit released = 1'b0, order_ok = 1'b1, got = 1'b0;
    issue(a);
    check(req_drive == 1'b1, "R2 req_drive after accept", req_drive, 1);
    check(bus_lines == DW'(a), "R2 address on bus", bus_lines, DW'(a));
    for (int i = 0; i < 300 && !got; i++) begin
      if (!req_drive) released = 1'b1;
      if (rsp_drive && !released) order_ok = 1'b0;
      if (done) got = 1'b1;
      else @(negedge clk_a);
    end
    check(order_ok, "R3 responder waits for release", order_ok, 1);
    check(got, "R4 done seen", got, 1);
    check(rdata == expect_word(a), "R4 read word", rdata, expect_word(a));
    @(negedge clk_a);
    check(done == 1'b0, "R6 done one cycle", done, 0);
    check(rdata == expect_word(a), "R6 rdata held", rdata, expect_word(a));
  endtask

  task automatic t_busy_ignore;
    bit got = 1'b0;
    int dones = 0;
    issue(4'd3);
    repeat (2) @(negedge clk_a);
    check(cmd_ready == 1'b0, "R8 not ready while busy", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_addr = 4'd12;
    @(negedge clk_a);
    cmd_valid = 1'b0;
    for (int i = 0; i < 300 && !got; i++) begin
      if (done) got = 1'b1;
      else @(negedge clk_a);
    end
    check(rdata == expect_word(3), "R8 in-flight read unaffected", rdata, expect_word(3));
    for (int i = 0; i < 80; i++) begin
      @(negedge clk_a);
      if (done) dones++;
    end
    check(dones == 0, "R8 no extra read", dones, 0);
  endtask

  task automatic t_timeout;
    int n = 0;
    bit seen_err = 1'b0, seen_done = 1'b0;
    rst_b_n = 1'b0;
    @(negedge clk_a);
    issue(4'd9);
    n = 1;
    while (n < TO + 20 && !seen_err) begin
      if (done) seen_done = 1'b1;
      if (err) seen_err = 1'b1;
      else begin
        @(negedge clk_a);
        n++;
      end
    end
    check(seen_err, "R7 err raised", seen_err, 1);
    check(n == TO + 1, "R7 err timing", n, TO + 1);
    check(!seen_done, "R7 no done", seen_done, 0);
    check({req_drive, busy} == 2'b00, "R7 released and idle", {req_drive, busy}, 0);
    @(negedge clk_a);
    check(err == 1'b0, "R7 err one cycle", err, 0);
    rst_b_n = 1'b1;
    repeat (4) @(negedge clk_a);
    t_read(4'd6);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read(4'd0);
    t_read(4'(DEPTH - 1));
    t_read(4'd7);
    t_read(4'd10);
    t_busy_ignore();
    t_timeout();
    check(overlap_a + overlap_b == 0, "R5 no shared-wire overlap", overlap_a + overlap_b, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule